// File: doc/BRIEF.md
# One-Time-Programmable Word Array Programming Interface

This block is the device-side logic of a serial one-time-programmable (OTP) memory while it is being written by an external programmer. In normal read mode it stays passive. A programmer switches it into programming mode with a fixed sequence on a digitally encoded programming supply, sampled on rising clock edges while both the select and enable lines are held high. Once in programming mode, the select/enable pair chooses what each rising clock edge does. It can shift a bit into a 32-bit word latch, shift a stored bit out for verification, or advance the word pointer.

A rising edge of the supply to its high level commits the latched word into the array. The commit is an AND, so a stored bit can go from one to zero but never back. Pulling select low empties the latch back to all ones, and a word committed from an empty latch leaves the array unchanged. If the programmer reads on past the last user word, the read reaches a 16-bit identification word. This word holds a manufacturer code and a device code. A chain output drops once the last user bit has been shifted out. An explicit power-down input ends programming mode.

Top module: `otpprog_top`

## Requirements
- R1: The supply encoding is 2'b00 off, 2'b01 access level, 2'b10 high level, and 2'b11 is treated as off. progMode rises after a rising edge that sees the supply at access level, provided the two rising edges before it saw the supply at high level, and all three edges saw selIn and enIn high. Any other sequence leaves progMode low.
- R2: In programming mode, powerDown high at a rising edge clears progMode. It also resets the word pointer, bit pointer, latch, chain state and dataOut. Array contents are kept.
- R3: In programming mode with the supply at access level, an edge with selIn=1 and enIn=1 shifts dataIn into the 32-bit latch, LSB first. After 32 such edges the first bit sits in bit 0.
- R4: An edge in programming mode with selIn=0 sets the latch to all ones. A commit that follows this without a new load leaves the addressed word unchanged.
- R5: When the supply goes from another level to high level in programming mode, the addressed user word becomes (old word AND latch). Bits can only be cleared. The array resets to all ones.
- R6: With the supply at access level, an edge with selIn=0 and enIn=1 places bit [bitPtr] of the addressed word on dataOut (registered, visible after that edge) and advances the pointer. After bit 31, the pointer moves to bit 0 of the next word.
- R7: An edge with selIn=1 and enIn=0 at access level advances the word pointer and returns the bit pointer to 0. The word pointer saturates at DEPTH, which is the identification location.
- R8: At word pointer DEPTH, the read gives the 16-bit value {DEV_ID, MFG_ID} LSB first (defaults 8'h29 then 8'h71). The bit pointer wraps modulo 16.
- R9: cascadeOut is 1 until the edge that shifts out bit 31 of word DEPTH-1. After that edge it is 0, and it stays 0 until programming mode is left.
- R10: dataOutEn is 1 only in programming mode at access level with selIn=0 and enIn=1. cascadeOutEn is 1 only in programming mode with the supply not at high level.
- R11: After reset, progMode=0, dataOutEn=0, cascadeOutEn=0, cascadeOut=1 and dataOut=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift/count clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyLvl | input | 2 | Encoded programming supply level |
| selIn | input | 1 | Select line level |
| enIn | input | 1 | Enable line level |
| powerDown | input | 1 | Leave programming mode |
| dataIn | input | 1 | Serial data from programmer |
| dataOut | output | 1 | Serial verify data |
| dataOutEn | output | 1 | Drive enable for dataOut |
| cascadeOut | output | 1 | Chain output, low after last user bit |
| cascadeOutEn | output | 1 | Drive enable for cascadeOut |
| progMode | output | 1 | Programming mode active |

## Verification
The main function is tried with random 32-bit words loaded LSB first into consecutive addresses. A second random word is committed over an already programmed address, which separates an AND commit from an overwrite. A word is loaded and then discarded by a select-low clear, which separates a cleared latch from a stale one. The entry sequence is tried both short of one high edge and with enable low, and both must be refused. A full readback runs through the whole array into the identification word, which places the chain drop on the exact final bit. Partial reads followed by a word advance show that the bit pointer restarts.

// File: rtl/otpprog_pkg.sv
package otpprog_pkg;

  typedef enum logic [1:0] {
    SUP_OFF    = 2'b00,
    SUP_ACCESS = 2'b01,
    SUP_HIGH   = 2'b10,
    SUP_RSVD   = 2'b11
  } supply_e;

  typedef enum logic [1:0] {
    M_READ = 2'd0,
    M_HI1  = 2'd1,
    M_HI2  = 2'd2,
    M_PROG = 2'd3
  } mode_e;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic incWord;
    logic clearLatch;
    logic commit;
    logic clearAll;
  } strobe_t;

endpackage

// File: rtl/otpprog_ctrl.sv
module otpprog_ctrl
  import otpprog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] supplyLvl,
  input  logic       selIn,
  input  logic       enIn,
  input  logic       powerDown,
  output logic       progMode,
  output logic       dataOutEn,
  output logic       cascadeOutEn,
  output strobe_t    stb
);

  supply_e sup;
  supply_e supPrev;
  mode_e   mode;
  mode_e   modeNxt;
  logic    bothHigh;
  logic    opOk;

  assign sup      = supply_e'(supplyLvl);
  assign bothHigh = selIn & enIn;

  always_comb begin
    modeNxt = mode;
    unique case (mode)
      M_READ: modeNxt = (bothHigh && sup == SUP_HIGH) ? M_HI1 : M_READ;
      M_HI1:  modeNxt = (bothHigh && sup == SUP_HIGH) ? M_HI2 : M_READ;
      M_HI2: begin
        if (bothHigh && sup == SUP_HIGH)        modeNxt = M_HI2;
        else if (bothHigh && sup == SUP_ACCESS) modeNxt = M_PROG;
        else                                    modeNxt = M_READ;
      end
      M_PROG: modeNxt = powerDown ? M_READ : M_PROG;
      default: modeNxt = M_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= M_READ;
      supPrev <= SUP_OFF;
    end else begin
      mode    <= modeNxt;
      supPrev <= sup;
    end
  end

  assign progMode = (mode == M_PROG);
  assign opOk     = progMode && (sup == SUP_ACCESS) && !powerDown;

  always_comb begin
    stb            = '0;
    stb.shiftIn    = opOk &  selIn &  enIn;
    stb.shiftOut   = opOk & ~selIn &  enIn;
    stb.incWord    = opOk &  selIn & ~enIn;
    stb.clearLatch = progMode & ~powerDown & ~selIn;
    stb.commit     = progMode & ~powerDown & (sup == SUP_HIGH) & (supPrev != SUP_HIGH);
    stb.clearAll   = progMode & powerDown;
  end

  assign dataOutEn    = stb.shiftOut;
  assign cascadeOutEn = progMode && (sup != SUP_HIGH);

  // R1
  entry_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $past(sup == SUP_ACCESS && selIn && enIn));

  // R2
  exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progMode && powerDown) |=> !progMode);

  // R6
  op_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.shiftOut, stb.incWord, stb.commit}));

endmodule

// File: rtl/otpprog_datapath.sv
module otpprog_datapath
  import otpprog_pkg::*;
#(
  parameter int          DEPTH  = 64,
  parameter int          WORD_W = 32,
  parameter logic [7:0]  MFG_ID = 8'h29,
  parameter logic [7:0]  DEV_ID = 8'h71
)(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    dataIn,
  output logic    dataOut,
  output logic    done
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW = $clog2(WORD_W);
  localparam logic [15:0] ID_WORD = {DEV_ID, MFG_ID};

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] latchQ;
  logic [CW-1:0]     wordCnt;
  logic [BW-1:0]     bitCnt;
  logic [WORD_W-1:0] curWord;
  logic              atId;
  logic              lastBit;
  logic              curBit;
  logic [DEPTH-1:0]  wrEn;

  assign atId    = (wordCnt == CW'(DEPTH));
  assign curWord = atId ? '1 : mem[wordCnt[AW-1:0]];
  assign lastBit = (bitCnt == BW'(WORD_W - 1));
  assign curBit  = atId ? ID_WORD[bitCnt[3:0]] : curWord[bitCnt];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    assign wrEn[gi] = stb.commit && !atId && (wordCnt == CW'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         mem[gi] <= '1;
      else if (wrEn[gi]) mem[gi] <= mem[gi] & latchQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '1;
    end else if (stb.clearAll || stb.clearLatch) begin
      latchQ <= '1;
    end else if (stb.shiftIn) begin
      latchQ <= {dataIn, latchQ[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      bitCnt  <= '0;
      done    <= 1'b0;
      dataOut <= 1'b0;
    end else if (stb.clearAll) begin
      wordCnt <= '0;
      bitCnt  <= '0;
      done    <= 1'b0;
      dataOut <= 1'b0;
    end else if (stb.incWord) begin
      bitCnt <= '0;
      if (!atId) wordCnt <= wordCnt + 1'b1;
    end else if (stb.shiftOut) begin
      dataOut <= curBit;
      if (atId) begin
        bitCnt <= (bitCnt[3:0] == 4'hF) ? '0 : bitCnt + 1'b1;
      end else if (lastBit) begin
        bitCnt  <= '0;
        wordCnt <= wordCnt + 1'b1;
        if (wordCnt == CW'(DEPTH - 1)) done <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R5
  otp_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !atId) |=> ((curWord | $past(curWord)) == $past(curWord)));

  // R7
  word_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CW'(DEPTH));

  // R7
  inc_bit_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incWord |=> (bitCnt == '0));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !stb.clearAll) |=> done);

endmodule

// File: rtl/otpprog_top.sv
module otpprog_top
  import otpprog_pkg::*;
#(
  parameter int         DEPTH  = 64,
  parameter int         WORD_W = 32,
  parameter logic [7:0] MFG_ID = 8'h29,
  parameter logic [7:0] DEV_ID = 8'h71
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] supplyLvl,
  input  logic       selIn,
  input  logic       enIn,
  input  logic       powerDown,
  input  logic       dataIn,
  output logic       dataOut,
  output logic       dataOutEn,
  output logic       cascadeOut,
  output logic       cascadeOutEn,
  output logic       progMode
);

  strobe_t stb;
  logic    done;

  otpprog_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supplyLvl    (supplyLvl),
    .selIn        (selIn),
    .enIn         (enIn),
    .powerDown    (powerDown),
    .progMode     (progMode),
    .dataOutEn    (dataOutEn),
    .cascadeOutEn (cascadeOutEn),
    .stb          (stb)
  );

  otpprog_datapath #(
    .DEPTH  (DEPTH),
    .WORD_W (WORD_W),
    .MFG_ID (MFG_ID),
    .DEV_ID (DEV_ID)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .done    (done)
  );

  assign cascadeOut = ~done;

endmodule

// File: tb/test_otpprog_top.sv
`timescale 1ns/1ps
module test_otpprog_top;

  localparam int DEPTH = 64;
  localparam logic [15:0] ID16 = {8'h71, 8'h29};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] supplyLvl;
  logic       selIn, enIn, powerDown, dataIn;
  logic       dataOut, dataOutEn, cascadeOut, cascadeOutEn, progMode;

  always #5 clk = ~clk;

  otpprog_top i_otpprog_top (
    .clk(clk), .rstN(rstN), .supplyLvl(supplyLvl), .selIn(selIn), .enIn(enIn),
    .powerDown(powerDown), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .cascadeOut(cascadeOut), .cascadeOutEn(cascadeOutEn), .progMode(progMode)
  );

  int tests = 0;
  int fails = 0;
  logic [31:0] mdl [DEPTH];
  logic [31:0] mLatch;
  int mWord, mBit;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expBit(int w, int b);
    if (w == DEPTH) return ID16[b % 16];
    return mdl[w][b];
  endfunction

  function automatic string tagFor(int w);
    if (w == DEPTH) return "R8";
    if (w == 3) return "R5";
    if (w == 4) return "R4";
    if (w < 8) return "R3";
    return "R6";
  endfunction

  task automatic drive(logic [1:0] s, logic c, logic o);
    supplyLvl = s; selIn = c; enIn = o;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic enterProg();
    drive(2'b10, 1, 1); tick(); tick();
    drive(2'b01, 1, 1); tick();
    chk("R1 entry", {31'd0, progMode}, 32'd1);
  endtask

  task automatic exitProg();
    powerDown = 1'b1; tick(); powerDown = 1'b0;
    mWord = 0; mBit = 0; mLatch = '1;
    chk("R2 exit", {31'd0, progMode}, 32'd0);
  endtask

  task automatic loadWord(logic [31:0] v);
    for (int i = 0; i < 32; i++) begin
      drive(2'b01, 1, 1); dataIn = v[i]; tick();
      mLatch = {v[i], mLatch[31:1]};
    end
  endtask

  task automatic clearLatch();
    drive(2'b01, 0, 0); tick(); mLatch = '1;
  endtask

  task automatic commitWord();
    drive(2'b10, 1, 1); #1;
    chk("R10 float at high", {31'd0, cascadeOutEn}, 32'd0);
    tick();
    if (mWord < DEPTH) mdl[mWord] = mdl[mWord] & mLatch;
  endtask

  task automatic incWord();
    drive(2'b01, 1, 0); tick();
    mBit = 0;
    if (mWord < DEPTH) mWord++;
  endtask

  task automatic readBits(int n, string req);
    for (int i = 0; i < n; i++) begin
      string t;
      logic e;
      drive(2'b01, 0, 1);
      if (i == 0) begin
        #1 chk("R10 out enable", {31'd0, dataOutEn}, 32'd1);
      end
      t = (req == "") ? tagFor(mWord) : req;
      e = expBit(mWord, mBit);
      tick();
      chk(t, {31'd0, dataOut}, {31'd0, e});
      mLatch = '1;
      if (mWord == DEPTH) mBit = (mBit + 1) % 16;
      else if (mBit == 31) begin mBit = 0; mWord++; end
      else mBit++;
    end
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '1;
    mLatch = '1; mWord = 0; mBit = 0;
    drive(2'b00, 1, 1); powerDown = 1'b0; dataIn = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();
    // R11 reset state
    chk("R11 progMode", {31'd0, progMode}, 32'd0);
    chk("R11 dataOutEn", {31'd0, dataOutEn}, 32'd0);
    chk("R11 cascadeOutEn", {31'd0, cascadeOutEn}, 32'd0);
    chk("R11 cascadeOut", {31'd0, cascadeOut}, 32'd1);
    chk("R11 dataOut", {31'd0, dataOut}, 32'd0);

    // R1 refused sequences: one high edge only, and enable low
    drive(2'b10, 1, 1); tick();
    drive(2'b01, 1, 1); tick();
    chk("R1 short entry", {31'd0, progMode}, 32'd0);
    drive(2'b10, 1, 0); tick(); tick();
    drive(2'b01, 1, 0); tick();
    chk("R1 enable low", {31'd0, progMode}, 32'd0);
    drive(2'b00, 0, 0); tick();

    enterProg();
    drive(2'b01, 1, 1); #1;
    chk("R10 chain enable", {31'd0, cascadeOutEn}, 32'd1);
    chk("R10 no out on load", {31'd0, dataOutEn}, 32'd0);

    // random words into addresses 0..7
    for (int w = 0; w < 8; w++) begin
      clearLatch();
      loadWord($urandom());
      commitWord();
      incWord();
    end

    exitProg();
    drive(2'b01, 0, 1); #1;
    chk("R10 off outside prog", {31'd0, dataOutEn}, 32'd0);
    chk("R10 chain off outside prog", {31'd0, cascadeOutEn}, 32'd0);

    // R5 second commit ANDs; R4 cleared latch commits nothing
    enterProg();
    incWord(); incWord(); incWord();
    clearLatch(); loadWord($urandom()); commitWord();
    incWord();
    loadWord(32'h0000_0000); clearLatch(); commitWord();
    exitProg();

    // R7 bit pointer restarts on word advance
    enterProg();
    readBits(5, "R6");
    incWord();
    readBits(32, "R7");
    exitProg();

    // full readback, chain drop, identification word
    enterProg();
    readBits(DEPTH * 32 - 1, "");
    chk("R9 before last", {31'd0, cascadeOut}, 32'd1);
    readBits(1, "");
    chk("R9 after last", {31'd0, cascadeOut}, 32'd0);
    readBits(19, "R8");
    chk("R9 stays low", {31'd0, cascadeOut}, 32'd0);
    exitProg();
    chk("R2 chain restored", {31'd0, cascadeOut}, 32'd1);

    // R7 saturation at identification word
    enterProg();
    for (int k = 0; k < DEPTH + 3; k++) incWord();
    readBits(16, "R7");
    exitProg();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule